// File: doc/BRIEF.md
# Dynamic-Fault March Self-Test Controller

This block is a built-in self-test sequencer for one synchronous single-port SRAM. Once started, it walks the whole array through a fixed march of six elements, 22 memory operations per word in total. Several of those elements read, write and read back the same word in back-to-back cycles. This exposes array cells whose behaviour depends on the operation that came just before, which a slower static pattern misses. The controller drives the memory's enable, write enable, address and write data. It compares every returned read word against the value it expects and reports pass or fail, the first failing address with its element index, and a one-cycle completion pulse.

Logical data 0 and 1 are turned into physical words through a data background chosen when the test starts. The choice is alternating columns (column stripe) or alternating rows (row stripe). The address is split into a row field and a column field, whose widths are parameters. The row field changes fastest, so consecutive accesses land on neighbouring rows of the same column.

Top module: `dfr_bist`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o`, `fail_o` and `mem_en_o` are 0.
- R2: One run issues exactly 22·N memory operations (N = 2^(ROW_BITS+COL_BITS)), one per cycle, as six elements in this order: ascending write 0; ascending read 0, write 0, read 0, write 1, read 1; ascending read 1, write 1, read 1, write 0, read 0; descending with the operations of the second element; descending with the operations of the third element; ascending read 0. All operations of an element are applied to one word before the next word is visited.
- R3: `mem_addr_o` = {row, col}, with the row in the upper bits. An ascending pass steps the row first and then the column, from {0,0} to all ones. A descending pass visits the same words in exactly the reverse order.
- R4: A word written or expected for logical value v at (row, col) has bit b equal to v XOR g. With `bg_sel_i` = 0 (column stripe), g = (col·DATA_W + b) mod 2. With `bg_sel_i` = 1 (row stripe), g = row mod 2.
- R5: A read is compared with `mem_rdata_i` in the cycle after it is issued. Any mismatch sets `fail_o`, which then stays set until the next accepted start.
- R6: `fail_addr_o` and `fail_elem_o` hold the address and the element index (0 to 5, in the order of R2) of the first mismatching read of the run. Later mismatches leave them unchanged, and the run still completes.
- R7: `done_o` is high for exactly one cycle, two cycles after the final read is issued, and no memory operation is issued while it is high.
- R8: A start is accepted only while the controller is idle. A `start_i` pulse during a run has no effect on the operation sequence. A start after completion begins again from element 0 and clears the fail state.
- R9: `bg_sel_i` is sampled only when a start is accepted. Changing it during a run does not alter the data of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken while idle |
| bg_sel_i | input | 1 | Background select: 0 column stripe, 1 row stripe |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ROW_BITS+COL_BITS | Memory address {row, col} |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after a read |
| done_o | output | 1 | Run-complete pulse |
| fail_o | output | 1 | A mismatch was seen in this run |
| fail_addr_o | output | ROW_BITS+COL_BITS | Address of the first mismatch |
| fail_elem_o | output | 3 | Element index of the first mismatch |

## Verification
The bench builds the controller with ROW_BITS = 2, COL_BITS = 2 and DATA_W = 3, which gives a 16-word array. With so few words, every operation of every run can be scoreboarded individually, and the walk through rows, the column wrap and the reversal of the descending elements all show up within a few hundred cycles. The odd word width makes the column-stripe phase flip from one column to the next, so the column term of the background formula is exercised along with the bit term. A behavioural memory with an injectable stuck-at-1 cell and a cell that cannot rise gives known first-failure addresses and elements. A fault-free run afterwards shows that the fail state is cleared.

// File: rtl/dfr_pkg.sv
// Shared definitions for the dynamic-fault march controller.
// Holds the controller state type and the fixed element/operation table.
package dfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } dfr_state_e;

    localparam logic [2:0] LAST_ELEM = 3'd5;

    // Number of operations per word in element e.
    function automatic logic [2:0] elem_len(input logic [2:0] e);
        return (e == 3'd0 || e == 3'd5) ? 3'd1 : 3'd5;
    endfunction

    // Elements 3 and 4 walk the array from the top address down.
    function automatic logic elem_down(input logic [2:0] e);
        return (e == 3'd3 || e == 3'd4);
    endfunction

    // Operation i of element e as {write, logical value}.
    function automatic logic [1:0] op_code(input logic [2:0] e, input logic [2:0] i);
        logic [1:0] r;
        r = 2'b00;
        case (e)
            3'd0: r = 2'b10;
            3'd1, 3'd3: begin
                case (i)
                    3'd0: r = 2'b00;
                    3'd1: r = 2'b10;
                    3'd2: r = 2'b00;
                    3'd3: r = 2'b11;
                    default: r = 2'b01;
                endcase
            end
            3'd2, 3'd4: begin
                case (i)
                    3'd0: r = 2'b01;
                    3'd1: r = 2'b11;
                    3'd2: r = 2'b01;
                    3'd3: r = 2'b10;
                    default: r = 2'b00;
                endcase
            end
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dfr_addr_gen.sv
// Fast-row address walker.
// Steps the row field first and carries into the column field; walks up or
// down. Assumes load and step are never asserted together.
module dfr_addr_gen #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                load_down_i,
    input  logic                dir_down_i,
    input  logic                step_i,
    output logic [ROW_BITS-1:0] row_o,
    output logic [COL_BITS-1:0] col_o,
    output logic                last_o
);
    localparam logic [ROW_BITS-1:0] ROW_MAX = {ROW_BITS{1'b1}};
    localparam logic [COL_BITS-1:0] COL_MAX = {COL_BITS{1'b1}};

    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;

    // Load the start corner or advance one word in the current direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load_i) begin
            row_q <= load_down_i ? ROW_MAX : '0;
            col_q <= load_down_i ? COL_MAX : '0;
        end else if (step_i) begin
            if (dir_down_i) begin
                row_q <= row_q - 1'b1;
                if (row_q == '0) col_q <= col_q - 1'b1;
            end else begin
                row_q <= row_q + 1'b1;
                if (row_q == ROW_MAX) col_q <= col_q + 1'b1;
            end
        end
    end

    // Final word of the pass in the current direction.
    always_comb begin
        last_o = dir_down_i ? (row_q == '0 && col_q == '0)
                            : (row_q == ROW_MAX && col_q == COL_MAX);
    end

    assign row_o = row_q;
    assign col_o = col_q;

    AST_ROW_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !last_o |=> row_q != $past(row_q)); // R3

    AST_COL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !dir_down_i && row_q != ROW_MAX |=> col_q == $past(col_q)); // R3

endmodule

// File: rtl/dfr_bg_gen.sv
// Data background mapper.
// Turns a logical value into a physical word for one (row, col) position,
// using either a column-stripe or a row-stripe pattern. Purely combinational.
module dfr_bg_gen #(
    parameter int DATA_W = 8
) (
    input  logic              sel_row_i,
    input  logic              row_lsb_i,
    input  logic              col_lsb_i,
    input  logic              val_i,
    output logic [DATA_W-1:0] word_o
);
    localparam logic ODD_W = (DATA_W % 2) == 1;

    // Column phase flips per column only when the word width is odd.
    logic col_phase;
    assign col_phase = col_lsb_i & ODD_W;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        localparam logic BIT_ODD = (b % 2) == 1;
        assign word_o[b] = val_i ^ (sel_row_i ? row_lsb_i : (col_phase ^ BIT_ODD));
    end

endmodule

// File: rtl/dfr_resp_cmp.sv
// Read response checker.
// Registers the expectation of each read issued, compares it with the memory
// data one cycle later and keeps the first failing address and element.
module dfr_resp_cmp #(
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              chk_valid_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [2:0]        elem_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              fail_o,
    output logic [AW-1:0]     fail_addr_o,
    output logic [2:0]        fail_elem_o
);
    logic              v_q;
    logic [DATA_W-1:0] exp_q;
    logic [AW-1:0]     addr_q;
    logic [2:0]        elem_q;
    logic              mismatch;
    logic              fail_q;
    logic [AW-1:0]     fail_addr_q;
    logic [2:0]        fail_elem_q;

    // Align the expectation with the read latency of the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            exp_q  <= '0;
            addr_q <= '0;
            elem_q <= '0;
        end else begin
            v_q    <= chk_valid_i;
            exp_q  <= exp_i;
            addr_q <= addr_i;
            elem_q <= elem_i;
        end
    end

    assign mismatch = v_q && (rdata_i != exp_q);

    // Sticky fail flag with first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            fail_elem_q <= '0;
        end else if (mismatch && !fail_q) begin
            fail_q      <= 1'b1;
            fail_addr_q <= addr_q;
            fail_elem_q <= elem_q;
        end
    end

    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;
    assign fail_elem_o = fail_elem_q;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q && !clear_i |=> fail_q); // R5

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch && !clear_i |=> fail_q); // R5

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q && !clear_i |=> $stable(fail_addr_q) && $stable(fail_elem_q)); // R6

endmodule

// File: rtl/dfr_bist.sv
// Dynamic-fault march self-test controller (top).
// Sequences six march elements over a single-port synchronous SRAM with a
// one-cycle read latency, one operation per cycle, and reports the result.
// Assumes the memory samples enable, write enable, address and data at the
// clock edge and returns read data in the following cycle.
module dfr_bist
    import dfr_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         bg_sel_i,
    output logic                         mem_en_o,
    output logic                         mem_we_o,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr_o,
    output logic [DATA_W-1:0]            mem_wdata_o,
    input  logic [DATA_W-1:0]            mem_rdata_i,
    output logic                         done_o,
    output logic                         fail_o,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr_o,
    output logic [2:0]                   fail_elem_o
);
    localparam int AW = ROW_BITS + COL_BITS;

    dfr_state_e          state_q;
    logic [2:0]          elem_q;
    logic [2:0]          opi_q;
    logic                bg_q;
    logic                done_q;
    logic                run;
    logic                start_ok;
    logic                last_op;
    logic [1:0]          op;
    logic [2:0]          elem_nx;
    logic                addr_last;
    logic                addr_load;
    logic                addr_load_down;
    logic                addr_step;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;
    logic [DATA_W-1:0]   word;

    assign run      = (state_q == ST_RUN);
    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign op       = op_code(elem_q, opi_q);
    assign last_op  = (opi_q == elem_len(elem_q) - 3'd1);
    assign elem_nx  = elem_q + 3'd1;

    assign addr_load      = start_ok || (run && last_op && addr_last && elem_q != LAST_ELEM);
    assign addr_load_down = start_ok ? 1'b0 : elem_down(elem_nx);
    assign addr_step      = run && last_op && !addr_last;

    // Controller state: idle, running the march, draining the last compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_RUN;
                ST_RUN:   if (last_op && addr_last && elem_q == LAST_ELEM) state_q <= ST_FLUSH;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Element and operation counters, background capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_q <= '0;
            opi_q  <= '0;
            bg_q   <= 1'b0;
        end else if (start_ok) begin
            elem_q <= '0;
            opi_q  <= '0;
            bg_q   <= bg_sel_i;
        end else if (run) begin
            if (!last_op) begin
                opi_q <= opi_q + 3'd1;
            end else begin
                opi_q <= '0;
                if (addr_last && elem_q != LAST_ELEM) elem_q <= elem_nx;
            end
        end
    end

    // Completion pulse once the final compare has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_FLUSH);
    end

    dfr_addr_gen #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (addr_load),
        .load_down_i (addr_load_down),
        .dir_down_i  (elem_down(elem_q)),
        .step_i      (addr_step),
        .row_o       (row),
        .col_o       (col),
        .last_o      (addr_last)
    );

    dfr_bg_gen #(
        .DATA_W (DATA_W)
    ) u_bg (
        .sel_row_i (bg_q),
        .row_lsb_i (row[0]),
        .col_lsb_i (col[0]),
        .val_i     (op[0]),
        .word_o    (word)
    );

    dfr_resp_cmp #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_ok),
        .chk_valid_i (run && !op[1]),
        .exp_i       (word),
        .addr_i      ({row, col}),
        .elem_i      (elem_q),
        .rdata_i     (mem_rdata_i),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o),
        .fail_elem_o (fail_elem_o)
    );

    assign mem_en_o    = run;
    assign mem_we_o    = run && op[1];
    assign mem_addr_o  = {row, col};
    assign mem_wdata_o = word;
    assign done_o      = done_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_en_o); // R7

    AST_ELEM_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> (elem_q == $past(elem_q) || elem_q == 3'($past(elem_q) + 3'd1))); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        run && start_i && !(last_op && addr_last && elem_q == LAST_ELEM) |=> run); // R8

endmodule

// File: tb/dfr_bist_tb.sv
// Scoreboard bench: a driver task queues every expected memory operation,
// a monitor pops and compares each one the controller issues.
module dfr_bist_tb_top;
    localparam int RB = 2;
    localparam int CB = 2;
    localparam int DW = 3;
    localparam int AW = RB + CB;
    localparam int NR = 1 << RB;
    localparam int NC = 1 << CB;
    localparam int N  = 1 << AW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          bg_sel = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          done, fail;
    logic [AW-1:0] fail_addr;
    logic [2:0]    fail_elem;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_op_cyc = 0;
    int op_cnt = 0;
    int done_cnt = 0;
    op_t exp_q[$];

    logic [DW-1:0] mem [N];
    int f_mode = 0;
    int f_addr = 0;
    int f_bit = 0;

    always #4 clk = ~clk;

    dfr_bist #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bg_sel_i(bg_sel),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .fail_elem_o(fail_elem)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural RAM with one injectable faulty bit (1 stuck-at-1, 2 cannot rise).
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                logic [DW-1:0] w;
                w = mem_wdata;
                if (f_mode == 1 && int'(mem_addr) == f_addr) w[f_bit] = 1'b1;
                if (f_mode == 2 && int'(mem_addr) == f_addr && !mem[mem_addr][f_bit]) w[f_bit] = 1'b0;
                mem[mem_addr] <= w;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    // Expected physical word per the background rule of R4.
    function automatic logic [DW-1:0] phys(input int v, input int r, input int c, input bit bg);
        logic [DW-1:0] w;
        for (int b = 0; b < DW; b++) begin
            int g;
            g = bg ? (r % 2) : ((c * DW + b) % 2);
            w[b] = logic'((v ^ g) & 1);
        end
        return w;
    endfunction

    // Driver: queue the full march of R2 in the fast-row order of R3.
    task automatic push_expected(input bit bg);
        // op code: 0 r0, 1 r1, 2 w0, 3 w1
        int seq [6][5] = '{'{2,0,0,0,0}, '{0,2,0,3,1}, '{1,3,1,2,0},
                           '{0,2,0,3,1}, '{1,3,1,2,0}, '{0,0,0,0,0}};
        int len [6] = '{1,5,5,5,5,1};
        exp_q.delete();
        for (int e = 0; e < 6; e++) begin
            for (int k = 0; k < N; k++) begin
                int idx, r, c;
                idx = (e == 3 || e == 4) ? (N - 1 - k) : k;
                c = idx / NR;
                r = idx % NR;
                for (int i = 0; i < len[e]; i++) begin
                    op_t o;
                    o.we   = seq[e][i] >= 2;
                    o.addr = AW'(r * NC + c);
                    o.data = phys(seq[e][i] % 2, r, c, bg);
                    exp_q.push_back(o);
                end
            end
        end
    endtask

    // Monitor: compare each issued operation against the queue.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && mem_en) begin
            op_cnt <= op_cnt + 1;
            last_op_cyc <= cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 extra operation", op_cnt, 22 * N);
            end else begin
                op_t o;
                o = exp_q.pop_front();
                check(mem_we == o.we, "R2 op kind", mem_we, o.we);
                check(mem_addr == o.addr, "R3 address order", mem_addr, o.addr);
                if (o.we) check(mem_wdata == o.data, "R4 write data", mem_wdata, o.data);
            end
        end
        if (rst_n && done) begin
            done_cnt <= done_cnt + 1;
            check(cyc - last_op_cyc == 2, "R7 done latency", cyc - last_op_cyc, 2);
        end
    end

    task automatic run_case(input bit bg, input int fm, input int fa, input int fb,
                            input bit exp_fail, input int exp_elem, input bit poke);
        int waited;
        for (int a = 0; a < N; a++) mem[a] = '0;
        f_mode = fm; f_addr = fa; f_bit = fb;
        push_expected(bg);
        @(negedge clk);
        op_cnt = 0; done_cnt = 0;
        start = 1'b1; bg_sel = bg;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 60) begin start = 1'b1; bg_sel = ~bg; end   // R8, R9 stimulus
            if (poke && waited == 61) start = 1'b0;
        end
        check(waited < 2000, "R7 watchdog", waited, 2000);
        @(negedge clk);
        check(!done, "R7 done width", done, 0);
        check(done_cnt == 1, "R7 done count", done_cnt, 1);
        check(op_cnt == 22 * N, "R2 operation count", op_cnt, 22 * N);
        check(exp_q.size() == 0, "R2 missing operations", exp_q.size(), 0);
        check(fail == exp_fail, "R5 fail flag", fail, exp_fail);
        if (exp_fail) begin
            check(int'(fail_addr) == fa, "R6 first fail address", fail_addr, fa);
            check(int'(fail_elem) == exp_elem, "R6 first fail element", fail_elem, exp_elem);
        end
        bg_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !fail && !mem_en, "R1 reset outputs", {done, fail, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !fail && !mem_en, "R1 after reset", {done, fail, mem_en}, 0);
        run_case(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);   // R2 R3 R4 clean column stripe
        run_case(1'b1, 0, 0, 0, 1'b0, 0, 1'b1);   // R8 R9 mid-run start and bg change
        run_case(1'b0, 1, 6, 1, 1'b1, 1, 1'b0);   // R5 R6 stuck-at-1
        run_case(1'b1, 2, 9, 2, 1'b1, 1, 1'b0);   // R6 cell that cannot rise
        run_case(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);   // R8 restart clears fail
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule